// File: doc/BRIEF.md
# Decimal Digit Correction Unit

This unit repairs the result of a binary add, subtract or multiply so that it reads as decimal again, and prepares two decimal digits for a binary divide. It takes an 8-bit low accumulator byte, an 8-bit high extension byte, the carry flag and the half-carry flag, together with a 3-bit operation code. It returns corrected bytes and flags one clock later.

Six corrections share one datapath. Two of them work on packed digits, with two decimal digits per byte. Two work on unpacked digits, with one digit per byte, and carry into or borrow from the high byte. The last two move digits between the bytes: one splits a binary byte into tens and units, and the other merges tens and units into one binary byte. Sign, zero and parity are always derived from the corrected low byte. The binary arithmetic itself takes place outside the unit.

Top module: `dadj_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every output is driven to 0 after that edge.
- R2: Outputs are registered. Inputs sampled at one rising edge produce their result right after that edge, and the outputs do not change between edges.
- R3: Operation code 0 (packed correction after add). Let L be the low 4 bits of the input low byte. The low fix applies when L > 9 or the half-carry input is 1: it adds 0x06, and the half-carry output equals the low fix. The high fix applies when the original low byte is above 0x99 or the carry input is 1: it adds 0x60, and the carry output equals the high fix. Both fixes may apply together, and sums wrap modulo 256.
- R4: Operation code 1 (packed correction after subtract). The tests and the flag outputs are the same as in R3, but the fixes subtract 0x06 and 0x60, modulo 256.
- R5: Operation code 2 (unpacked correction after add). When L > 9 or the half-carry input is 1, the unit adds 6 to the low byte and 1 to the high byte, and sets both carry outputs. Otherwise both carry outputs are cleared. In every case, the upper 4 bits of the output low byte are 0.
- R6: Operation code 3 (unpacked correction after subtract). The test is the same as in R5, but the unit subtracts 6 from the low byte and 1 from the high byte, modulo 256. The carry input plays no part in the test.
- R7: Operation code 4 (split into digits). The output high byte is the input low byte divided by 10, the output low byte is the remainder, and the carry and half-carry outputs equal their inputs.
- R8: Operation code 5 (merge digits). The output low byte is (high × 10 + low) mod 256, the output high byte is 0, and the carry and half-carry outputs equal their inputs.
- R9: For every operation, `sf_o` is bit 7 of the output low byte, `zf_o` is 1 exactly when that byte is 0, and `pf_o` is 1 when that byte has an even number of one bits.
- R10: The packed operations (codes 0 and 1) pass the high byte through unchanged.
- R11: Operation codes 6 and 7 pass both bytes and both carry flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Correction select, codes 0 to 5 (6 and 7 pass through) |
| al_i | input | 8 | Low accumulator byte |
| ah_i | input | 8 | High extension byte |
| cf_i | input | 1 | Carry flag in |
| af_i | input | 1 | Half-carry flag in |
| al_o | output | 8 | Corrected low byte |
| ah_o | output | 8 | Corrected high byte |
| cf_o | output | 1 | Carry flag out |
| af_o | output | 1 | Half-carry flag out |
| sf_o | output | 1 | Sign of the output low byte |
| zf_o | output | 1 | Output low byte is zero |
| pf_o | output | 1 | Even parity of the output low byte |

## Verification
The bench builds the unit with its default nibble width of 4, which gives the 8-bit byte, decimal digit limit 9 and divisor 10 used by every expected value. At this width, a short vector table reaches all the corner cases: both packed fixes firing together and wrapping to zero, a byte of exactly 0x9A, the high byte wrapping through 0xFF in both directions for the unpacked forms, the largest split (255 into 25 and 5), and a merge that overflows past 255. Directed steps cover reset in the middle of a run and the one-cycle timing of results.

// File: rtl/dadj_pkg.sv
package dadj_pkg;
  typedef enum logic [2:0] {
    ADJ_PACK_ADD    = 3'd0,
    ADJ_PACK_SUB    = 3'd1,
    ADJ_UNP_ADD     = 3'd2,
    ADJ_UNP_SUB     = 3'd3,
    ADJ_TO_DIGITS   = 3'd4,
    ADJ_FROM_DIGITS = 3'd5
  } adj_op_e;
endpackage

// File: rtl/dadj_packed.sv
module dadj_packed #(
  parameter int NIB_W = 4
) (
  input  logic [2*NIB_W-1:0] a_i,
  input  logic               cf_i,
  input  logic               af_i,
  input  logic               sub_i,
  output logic [2*NIB_W-1:0] y_o,
  output logic               cf_o,
  output logic               af_o
);
  localparam int W = 2 * NIB_W;
  localparam logic [NIB_W-1:0] DIG_MAX = NIB_W'(9);
  localparam logic [W-1:0] LO_FIX = W'(6);
  localparam logic [W-1:0] HI_FIX = W'(6) << NIB_W;
  localparam logic [W-1:0] BYTE_MAX = {DIG_MAX, DIG_MAX};

  logic lo_hit, hi_hit;
  logic [W-1:0] lo_amt, hi_amt, mid;

  always_comb begin
    // both tests look at the original byte so they evaluate side by side
    lo_hit = (a_i[NIB_W-1:0] > DIG_MAX) | af_i;
    hi_hit = (a_i > BYTE_MAX) | cf_i;
    lo_amt = lo_hit ? LO_FIX : '0;
    hi_amt = hi_hit ? HI_FIX : '0;
    mid    = sub_i ? (a_i - lo_amt) : (a_i + lo_amt);
    y_o    = sub_i ? (mid - hi_amt) : (mid + hi_amt);
    cf_o   = hi_hit;
    af_o   = lo_hit;
  end
endmodule

// File: rtl/dadj_unpacked.sv
module dadj_unpacked #(
  parameter int NIB_W = 4
) (
  input  logic [2*NIB_W-1:0] al_i,
  input  logic [2*NIB_W-1:0] ah_i,
  input  logic               af_i,
  input  logic               sub_i,
  output logic [2*NIB_W-1:0] al_o,
  output logic [2*NIB_W-1:0] ah_o,
  output logic               fix_o
);
  localparam int W = 2 * NIB_W;
  localparam logic [NIB_W-1:0] DIG_MAX = NIB_W'(9);
  localparam logic [W-1:0] LO_FIX = W'(6);
  localparam logic [W-1:0] ONE = W'(1);

  logic hit;
  logic [W-1:0] lo_sum;

  always_comb begin
    hit = (al_i[NIB_W-1:0] > DIG_MAX) | af_i;
    if (!hit) begin
      lo_sum = al_i;
      ah_o   = ah_i;
    end else if (sub_i) begin
      lo_sum = al_i - LO_FIX;
      ah_o   = ah_i - ONE;
    end else begin
      lo_sum = al_i + LO_FIX;
      ah_o   = ah_i + ONE;
    end
    al_o  = {{NIB_W{1'b0}}, lo_sum[NIB_W-1:0]};
    fix_o = hit;
  end
endmodule

// File: rtl/dadj_digits.sv
module dadj_digits #(
  parameter int NIB_W = 4
) (
  input  logic [2*NIB_W-1:0] al_i,
  input  logic [2*NIB_W-1:0] ah_i,
  input  logic               split_i,
  output logic [2*NIB_W-1:0] al_o,
  output logic [2*NIB_W-1:0] ah_o
);
  localparam int W = 2 * NIB_W;
  localparam logic [W-1:0] TEN = W'(10);

  always_comb begin
    if (split_i) begin
      ah_o = al_i / TEN;
      al_o = al_i % TEN;
    end else begin
      al_o = (ah_i * TEN) + al_i;
      ah_o = '0;
    end
  end
endmodule

// File: rtl/dadj_unit.sv
module dadj_unit
  import dadj_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         op_i,
  input  logic [2*NIB_W-1:0] al_i,
  input  logic [2*NIB_W-1:0] ah_i,
  input  logic               cf_i,
  input  logic               af_i,
  output logic [2*NIB_W-1:0] al_o,
  output logic [2*NIB_W-1:0] ah_o,
  output logic               cf_o,
  output logic               af_o,
  output logic               sf_o,
  output logic               zf_o,
  output logic               pf_o
);
  localparam int W = 2 * NIB_W;

  logic [W-1:0] pk_al, up_al, up_ah, dg_al, dg_ah;
  logic         pk_cf, pk_af, up_fix;
  logic [W-1:0] nx_al, nx_ah;
  logic         nx_cf, nx_af;

  dadj_packed #(.NIB_W(NIB_W)) u_pk (
    .a_i(al_i), .cf_i(cf_i), .af_i(af_i),
    .sub_i(op_i == ADJ_PACK_SUB),
    .y_o(pk_al), .cf_o(pk_cf), .af_o(pk_af)
  );

  dadj_unpacked #(.NIB_W(NIB_W)) u_up (
    .al_i(al_i), .ah_i(ah_i), .af_i(af_i),
    .sub_i(op_i == ADJ_UNP_SUB),
    .al_o(up_al), .ah_o(up_ah), .fix_o(up_fix)
  );

  dadj_digits #(.NIB_W(NIB_W)) u_dg (
    .al_i(al_i), .ah_i(ah_i),
    .split_i(op_i == ADJ_TO_DIGITS),
    .al_o(dg_al), .ah_o(dg_ah)
  );

  always_comb begin
    nx_al = al_i;
    nx_ah = ah_i;
    nx_cf = cf_i;
    nx_af = af_i;
    case (op_i)
      ADJ_PACK_ADD, ADJ_PACK_SUB: begin
        nx_al = pk_al;
        nx_cf = pk_cf;
        nx_af = pk_af;
      end
      ADJ_UNP_ADD, ADJ_UNP_SUB: begin
        nx_al = up_al;
        nx_ah = up_ah;
        nx_cf = up_fix;
        nx_af = up_fix;
      end
      ADJ_TO_DIGITS, ADJ_FROM_DIGITS: begin
        nx_al = dg_al;
        nx_ah = dg_ah;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      al_o <= '0;
      ah_o <= '0;
      cf_o <= 1'b0;
      af_o <= 1'b0;
      sf_o <= 1'b0;
      zf_o <= 1'b0;
      pf_o <= 1'b0;
    end else begin
      al_o <= nx_al;
      ah_o <= nx_ah;
      cf_o <= nx_cf;
      af_o <= nx_af;
      sf_o <= nx_al[W-1];
      zf_o <= ~|nx_al;
      pf_o <= ~^nx_al;
    end
  end

  assert_pack_ah_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == ADJ_PACK_ADD || $past(op_i) == ADJ_PACK_SUB))
      |-> ah_o == $past(ah_i));

  assert_unp_high_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == ADJ_UNP_ADD || $past(op_i) == ADJ_UNP_SUB))
      |-> al_o[W-1:NIB_W] == '0);

  assert_split_range_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == ADJ_TO_DIGITS) |-> al_o < W'(10));

  assert_split_flags_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == ADJ_TO_DIGITS || $past(op_i) == ADJ_FROM_DIGITS))
      |-> (cf_o == $past(cf_i) && af_o == $past(af_i)));

  assert_merge_ah_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == ADJ_FROM_DIGITS) |-> ah_o == '0);

  assert_zero_flag_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> zf_o == (al_o == '0));

  assert_unp_flags_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == ADJ_UNP_ADD || $past(op_i) == ADJ_UNP_SUB))
      |-> cf_o == af_o);
endmodule

// File: tb/sim_dadj_unit.sv
`timescale 1ns/1ps
module sim_dadj_unit;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] op_i;
  logic [7:0] al_i, ah_i;
  logic       cf_i, af_i;
  logic [7:0] al_o, ah_o;
  logic       cf_o, af_o, sf_o, zf_o, pf_o;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dadj_unit u0 (
    .clk(clk), .rst(rst), .op_i(op_i), .al_i(al_i), .ah_i(ah_i),
    .cf_i(cf_i), .af_i(af_i), .al_o(al_o), .ah_o(ah_o), .cf_o(cf_o),
    .af_o(af_o), .sf_o(sf_o), .zf_o(zf_o), .pf_o(pf_o)
  );

  // op | al | ah | {cf,af} in | expected al | expected ah | expected {cf,af}
  localparam int NV = 26;
  localparam logic [43:0] VEC [NV] = '{
    44'h0_AE_12_0_14_12_3,
    44'h0_45_12_0_45_12_0,
    44'h0_40_12_1_46_12_1,
    44'h0_00_12_2_60_12_2,
    44'h0_9A_12_0_00_12_3,
    44'h1_2F_34_1_29_34_1,
    44'h1_F0_34_2_90_34_2,
    44'h1_55_34_0_55_34_0,
    44'h1_EB_34_3_85_34_3,
    44'h2_0C_03_0_02_04_3,
    44'h2_36_00_0_06_00_0,
    44'h2_11_05_1_07_06_3,
    44'h2_0A_FF_0_00_00_3,
    44'h3_FF_02_1_09_01_3,
    44'h3_05_07_2_05_07_0,
    44'h3_03_00_1_0D_FF_3,
    44'h4_3F_99_2_03_06_2,
    44'h4_FF_00_1_05_19_1,
    44'h4_00_55_0_00_00_0,
    44'h4_09_07_3_09_00_3,
    44'h5_03_07_0_49_00_0,
    44'h5_09_09_3_63_00_3,
    44'h5_05_20_0_45_00_0,
    44'h5_00_00_2_00_00_2,
    44'h6_A5_5A_3_A5_5A_3,
    44'h7_00_11_0_00_11_0
  };

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [3:0] op);
    case (op)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd4: return "R7";
      4'd5: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic drive(input logic [2:0] op, input logic [7:0] al,
                       input logic [7:0] ah, input logic [1:0] fl);
    op_i = op; al_i = al; ah_i = ah; cf_i = fl[1]; af_i = fl[0];
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1;
    drive(3'd6, 8'hA5, 8'h5A, 2'b11);
    repeat (2) @(negedge clk);
    // R1: reset clears all outputs despite nonzero inputs
    chk("R1", "al", al_o, 8'h00);
    chk("R1", "ah", ah_o, 8'h00);
    chk("R1", "flags", {3'b0, cf_o, af_o, sf_o, zf_o, pf_o}, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      string tg;
      v = VEC[i];
      tg = op_tag(v[43:40]);
      drive(v[42:40], v[39:32], v[31:24], v[21:20]);
      @(negedge clk);
      chk(tg, "al", al_o, v[19:12]);
      chk((v[43:40] <= 4'd1) ? "R10" : tg, "ah", ah_o, v[11:4]);
      chk(tg, "cf_af", {6'b0, cf_o, af_o}, {6'b0, v[1:0]});
      // R9: sign, zero and parity from the expected low byte
      chk("R9", "szp", {5'b0, sf_o, zf_o, pf_o},
          {5'b0, v[19], v[19:12] == 8'h00, ~^v[19:12]});
    end

    // R2: result appears after one edge and holds until the next
    drive(3'd4, 8'h3F, 8'h00, 2'b00);
    @(negedge clk);
    chk("R2", "al after edge", al_o, 8'h03);
    drive(3'd6, 8'h77, 8'h00, 2'b00);
    #1;
    chk("R2", "al before edge", al_o, 8'h03);
    @(negedge clk);
    chk("R2", "al next edge", al_o, 8'h77);

    // R1: reset in the middle of a run
    drive(3'd5, 8'h09, 8'h09, 2'b11);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "al mid-run", al_o, 8'h00);
    chk("R1", "flags mid-run", {3'b0, cf_o, af_o, sf_o, zf_o, pf_o}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R8", "al after reset", al_o, 8'h63);

    done = 1'b1;
    finish_run();
  end
endmodule